// File: doc/BRIEF.md
# Move and Memory Access Unit

This execution unit carries out the move family of a 16-bit processor. It copies a register into another register, either whole or one byte at a time. It stores a register to memory at the address held in a second register, and loads memory into a register. It also places an 8-bit immediate into either byte of a register. The unit decodes the instruction itself. It drives a byte-addressed, little-endian memory port and returns a register write-back with its own valid strobe. The register file and the memory sit outside the unit: the unit reports which register indices it needs and receives their values back in the same cycle.

Every result that reaches the register file appears exactly one cycle after the instruction is issued. For register moves and immediates this cycle is the registered stage. For loads it is the cycle in which the memory returns its data. A word access to an odd address is rejected. It makes no memory request and writes no register, and it raises a fault for one cycle instead.

Instruction layout, bit 15 first: a 4-bit opcode [15:12], a destination register [11:9], a form bit [8], and a source register [7:5]. In the move forms these are followed by dest-byte [4], src-byte [3], byte/word [2], a reserved bit [1] and a load/store bit [0]. In the immediate form the low eight bits [7:0] carry the immediate.

Top module: `mov_unit`

## Requirements
- R1: Opcode 0100 with bit 8 = 0, byte/word bit [2] = 0 (word) and bit [1] = 0 writes the source register value unchanged to the destination register (wb_idx_o = bits [11:9]). This happens one cycle after issue, with wb_en_o high for that single cycle and no memory request.
- R2: The same form with bit [2] = 1 (byte) takes the source byte chosen by bit [3] (0 low, 1 high). It writes that byte into the destination byte chosen by bit [4] (0 low, 1 high) and keeps the other destination byte.
- R3: Opcode 0101 writes the immediate in bits [7:0] into the low byte (bit 8 = 0) or the high byte (bit 8 = 1) of the destination register, one cycle after issue. The other byte keeps its value.
- R4: A store is opcode 0100 with bit 8 = 1 and bit 0 = 0. In the issue cycle a word store drives mem_req_o = 1, mem_we_o = 1, mem_be_o = 11, the address from the destination register and the data from the source register. It produces no register write.
- R5: A byte store enables only the addressed lane: mem_be_o = 01 for an even address, 10 for an odd one. The source byte chosen by bit [3] is placed in that lane.
- R6: A load is opcode 0100 with bit 8 = 1 and bit 0 = 1. In the issue cycle it drives mem_req_o = 1, mem_we_o = 0 and the address from the source register. The next cycle writes mem_rdata_i to the destination register.
- R7: A byte load takes the lane given by address bit 0 (even = low byte of the returned word). It writes that lane into the destination byte chosen by bit [4] and keeps the other byte.
- R8: A word load or store whose address has bit 0 = 1 makes no memory request and no register write. It raises fault_o for exactly the one cycle after issue.
- R9: With valid_i low, any opcode other than 0100/0101, or opcode 0100 with reserved bit [1] = 1, the unit makes no request, no write-back and no fault.
- R10: During and right after reset, mem_req_o, wb_en_o and fault_o are low.
- R11: In word moves, bits [4] and [3] have no effect on the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Instruction word |
| rd_idx_o | output | 3 | Index of the destination/address register to read |
| rs_idx_o | output | 3 | Index of the source register to read |
| rd_val_i | input | 16 | Current value of register rd_idx_o |
| rs_val_i | input | 16 | Current value of register rs_idx_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Byte address |
| mem_be_o | output | 2 | Byte enables, bit 0 = even-address lane |
| mem_wdata_o | output | 16 | Write data, little-endian lanes |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| wb_en_o | output | 1 | Register write-back strobe |
| wb_idx_o | output | 3 | Register written |
| wb_data_o | output | 16 | Value written |
| fault_o | output | 1 | Misaligned word access, one cycle |

## Verification
Several properties are checked on every clock. A word request never carries an odd address. A byte request enables exactly one lane. A fault never coincides with a write-back. A store is never followed by a write-back. Every write-back or fault follows an issued instruction. The bench scenarios are what show the values themselves: which byte lands where, that the untouched byte survives, that stored bytes can be read back through loads, and that a rejected store left memory unchanged.

// File: rtl/mov_pkg.sv
package mov_pkg;
  localparam int INSTR_W = 16;
  localparam int RIDX_W  = 3;
  localparam int IMM_W   = 8;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0] OPC_MOVE = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_IMM  = 4'b0101;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_MOVE,
    OP_STORE,
    OP_LOAD,
    OP_IMM
  } op_e;

  typedef enum logic [1:0] {
    PEND_IDLE,
    PEND_DIRECT,
    PEND_LOAD
  } pend_e;

  typedef logic [RIDX_W-1:0] ridx_t;
endpackage

// File: rtl/mov_decode.sv
module mov_decode
  import mov_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output op_e                op_o,
  output ridx_t              rd_o,
  output ridx_t              rs_o,
  output logic               dst_hi_o,
  output logic               src_hi_o,
  output logic               byte_o,
  output logic               imm_hi_o,
  output logic [IMM_W-1:0]   imm_o
);
  logic [OPC_W-1:0] opc;
  logic             form_mem;
  logic             resv;
  logic             is_load;

  assign opc      = instr_i[15:12];
  assign form_mem = instr_i[8];
  assign resv     = instr_i[1];
  assign is_load  = instr_i[0];

  assign rd_o     = instr_i[11:9];
  assign rs_o     = instr_i[7:5];
  assign dst_hi_o = instr_i[4];
  assign src_hi_o = instr_i[3];
  assign byte_o   = instr_i[2];
  assign imm_hi_o = instr_i[8];
  assign imm_o    = instr_i[7:0];

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      if (opc == OPC_IMM) begin
        op_o = OP_IMM;
      end else if (opc == OPC_MOVE && !resv) begin
        if (!form_mem)    op_o = OP_MOVE;
        else if (is_load) op_o = OP_LOAD;
        else              op_o = OP_STORE;
      end
    end
  end
endmodule

// File: rtl/mov_lane_merge.sv
module mov_lane_merge #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   base_i,
  input  logic [DATA_W/2-1:0] part_i,
  input  logic                hi_i,
  output logic [DATA_W-1:0]   merged_o
);
  localparam int HALF  = DATA_W / 2;
  localparam int LANES = 2;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*HALF +: HALF] =
      (hi_i == l[0]) ? part_i : base_i[l*HALF +: HALF];
  end
endmodule

// File: rtl/mov_mem_port.sv
module mov_mem_port
  import mov_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic              byte_i,
  input  logic              src_hi_i,
  input  logic [DATA_W-1:0] rd_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  output logic              req_o,
  output logic              we_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [1:0]        be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              misalign_o,
  output logic              lane_hi_o
);
  localparam int HALF = DATA_W / 2;

  logic            is_mem;
  logic            is_store;
  logic [HALF-1:0] src_part;
  logic [1:0]      be_raw;

  assign is_store = (op_i == OP_STORE);
  assign is_mem   = is_store || (op_i == OP_LOAD);
  // store: address in dest reg; load: address in source reg
  assign addr_o    = is_store ? rd_val_i : rs_val_i;
  assign lane_hi_o = addr_o[0];

  assign misalign_o = is_mem && !byte_i && addr_o[0];
  assign req_o      = is_mem && !misalign_o;
  assign we_o       = req_o && is_store;

  assign src_part = src_hi_i ? rs_val_i[DATA_W-1:HALF] : rs_val_i[HALF-1:0];
  assign be_raw   = byte_i ? (addr_o[0] ? 2'b10 : 2'b01) : 2'b11;
  assign be_o     = req_o ? be_raw : 2'b00;

  always_comb begin
    wdata_o = '0;
    if (we_o) wdata_o = byte_i ? {src_part, src_part} : rs_val_i;
  end
endmodule

// File: rtl/mov_wb.sv
module mov_wb
  import mov_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic              misalign_i,
  input  ridx_t             rd_i,
  input  logic              byte_i,
  input  logic              dst_hi_i,
  input  logic              src_hi_i,
  input  logic              imm_hi_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              lane_hi_i,
  input  logic [DATA_W-1:0] rd_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wb_en_o,
  output ridx_t             wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              fault_o
);
  localparam int HALF = DATA_W / 2;

  pend_e             pend_q, pend_d;
  ridx_t             idx_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ld_byte_q, ld_lane_q, ld_dst_q;
  logic              fault_q;

  logic [HALF-1:0]   mv_part;
  logic              mv_hi;
  logic [DATA_W-1:0] mv_merged;
  logic [HALF-1:0]   ld_part;
  logic [DATA_W-1:0] ld_merged;

  // issue-side byte placement (register move or immediate)
  assign mv_part = (op_i == OP_IMM) ? HALF'(imm_i)
                 : (src_hi_i ? rs_val_i[DATA_W-1:HALF] : rs_val_i[HALF-1:0]);
  assign mv_hi   = (op_i == OP_IMM) ? imm_hi_i : dst_hi_i;

  mov_lane_merge #(.DATA_W(DATA_W)) u_mv_merge (
    .base_i  (rd_val_i),
    .part_i  (mv_part),
    .hi_i    (mv_hi),
    .merged_o(mv_merged)
  );

  always_comb begin
    pend_d = PEND_IDLE;
    data_d = rd_val_i;
    unique case (op_i)
      OP_MOVE: begin
        pend_d = PEND_DIRECT;
        data_d = byte_i ? mv_merged : rs_val_i;
      end
      OP_IMM: begin
        pend_d = PEND_DIRECT;
        data_d = mv_merged;
      end
      OP_LOAD: begin
        pend_d = misalign_i ? PEND_IDLE : PEND_LOAD;
        data_d = rd_val_i;  // kept for byte merge on return
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= PEND_IDLE;
      idx_q     <= '0;
      data_q    <= '0;
      ld_byte_q <= 1'b0;
      ld_lane_q <= 1'b0;
      ld_dst_q  <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      idx_q     <= rd_i;
      data_q    <= data_d;
      ld_byte_q <= byte_i;
      ld_lane_q <= lane_hi_i;
      ld_dst_q  <= dst_hi_i;
      fault_q   <= misalign_i;
    end
  end

  // return-side byte placement
  assign ld_part = ld_lane_q ? rdata_i[DATA_W-1:HALF] : rdata_i[HALF-1:0];

  mov_lane_merge #(.DATA_W(DATA_W)) u_ld_merge (
    .base_i  (data_q),
    .part_i  (ld_part),
    .hi_i    (ld_dst_q),
    .merged_o(ld_merged)
  );

  assign wb_en_o   = (pend_q != PEND_IDLE);
  assign wb_idx_o  = idx_q;
  assign wb_data_o = (pend_q == PEND_LOAD) ? (ld_byte_q ? ld_merged : rdata_i) : data_q;
  assign fault_o   = fault_q;

  p_fault_excl_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !wb_en_o);

  p_wb_after_issue_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> ($past(op_i) != OP_NONE) && ($past(op_i) != OP_STORE));

  p_fault_after_mem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($past(op_i) == OP_LOAD) || ($past(op_i) == OP_STORE));
endmodule

// File: rtl/mov_unit.sv
module mov_unit
  import mov_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [INSTR_W-1:0]  instr_i,
  output logic [RIDX_W-1:0]   rd_idx_o,
  output logic [RIDX_W-1:0]   rs_idx_o,
  input  logic [DATA_W-1:0]   rd_val_i,
  input  logic [DATA_W-1:0]   rs_val_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [DATA_W-1:0]   mem_addr_o,
  output logic [1:0]          mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                wb_en_o,
  output logic [RIDX_W-1:0]   wb_idx_o,
  output logic [DATA_W-1:0]   wb_data_o,
  output logic                fault_o
);
  op_e              op;
  ridx_t            rd, rs;
  logic             dst_hi, src_hi, is_byte, imm_hi;
  logic [IMM_W-1:0] imm;
  logic             misalign, lane_hi;

  mov_decode u_decode (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .op_o    (op),
    .rd_o    (rd),
    .rs_o    (rs),
    .dst_hi_o(dst_hi),
    .src_hi_o(src_hi),
    .byte_o  (is_byte),
    .imm_hi_o(imm_hi),
    .imm_o   (imm)
  );

  assign rd_idx_o = rd;
  assign rs_idx_o = rs;

  mov_mem_port #(.DATA_W(DATA_W)) u_mem_port (
    .op_i      (op),
    .byte_i    (is_byte),
    .src_hi_i  (src_hi),
    .rd_val_i  (rd_val_i),
    .rs_val_i  (rs_val_i),
    .req_o     (mem_req_o),
    .we_o      (mem_we_o),
    .addr_o    (mem_addr_o),
    .be_o      (mem_be_o),
    .wdata_o   (mem_wdata_o),
    .misalign_o(misalign),
    .lane_hi_o (lane_hi)
  );

  mov_wb #(.DATA_W(DATA_W)) u_wb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .misalign_i(misalign),
    .rd_i      (rd),
    .byte_i    (is_byte),
    .dst_hi_i  (dst_hi),
    .src_hi_i  (src_hi),
    .imm_hi_i  (imm_hi),
    .imm_i     (imm),
    .lane_hi_i (lane_hi),
    .rd_val_i  (rd_val_i),
    .rs_val_i  (rs_val_i),
    .rdata_i   (mem_rdata_i),
    .wb_en_o   (wb_en_o),
    .wb_idx_o  (wb_idx_o),
    .wb_data_o (wb_data_o),
    .fault_o   (fault_o)
  );

  p_word_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_be_o == 2'b11) |-> !mem_addr_o[0]);

  p_byte_one_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_be_o != 2'b11) |-> ($countones(mem_be_o) == 1));

  p_store_no_wb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> !wb_en_o);

  p_fault_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(valid_i));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !mem_req_o);
endmodule

// File: tb/mov_unit_tb.sv
module mov_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [2:0]  rd_idx, rs_idx;
  logic [15:0] rd_val = '0, rs_val = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [1:0]  mem_be;
  logic [15:0] mem_rdata = '0;
  logic        wb_en, fault;
  logic [2:0]  wb_idx;
  logic [15:0] wb_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] mem [0:255];

  always #2 clk = ~clk;

  mov_unit u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .valid_i    (valid),
    .instr_i    (instr),
    .rd_idx_o   (rd_idx),
    .rs_idx_o   (rs_idx),
    .rd_val_i   (rd_val),
    .rs_val_i   (rs_val),
    .mem_req_o  (mem_req),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_be_o   (mem_be),
    .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .wb_en_o    (wb_en),
    .wb_idx_o   (wb_idx),
    .wb_data_o  (wb_data),
    .fault_o    (fault)
  );

  // little-endian byte memory, read data one cycle after request
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) mem[{mem_addr[7:1], 1'b0}] <= mem_wdata[7:0];
        if (mem_be[1]) mem[{mem_addr[7:1], 1'b1}] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= {mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]};
      end
    end
  end

  function automatic logic [15:0] f_move(input logic [2:0] rd, input logic [2:0] rs,
                                         input logic dhi, input logic shi, input logic byt);
    return {4'b0100, rd, 1'b0, rs, dhi, shi, byt, 2'b00};
  endfunction
  function automatic logic [15:0] f_store(input logic [2:0] rd, input logic [2:0] rs,
                                          input logic shi, input logic byt);
    return {4'b0100, rd, 1'b1, rs, 1'b0, shi, byt, 2'b00};
  endfunction
  function automatic logic [15:0] f_load(input logic [2:0] rd, input logic [2:0] rs,
                                         input logic dhi, input logic byt);
    return {4'b0100, rd, 1'b1, rs, dhi, 1'b0, byt, 2'b01};
  endfunction
  function automatic logic [15:0] f_imm(input logic [2:0] rd, input logic hi, input logic [7:0] v);
    return {4'b0101, rd, hi, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive an instruction; returns mid low phase of the issue cycle
  task automatic issue(input logic [15:0] ins, input logic [15:0] rdv, input logic [15:0] rsv);
    @(negedge clk);
    valid  = 1'b1;
    instr  = ins;
    rd_val = rdv;
    rs_val = rsv;
    #1;
  endtask

  // advance past the issue edge and drop the instruction
  task automatic retire();
    @(posedge clk);
    #1;
    valid = 1'b0;
    instr = '0;
  endtask

  task automatic t_reset();
    check("R10 req", mem_req, 0);
    check("R10 wb", wb_en, 0);
    check("R10 fault", fault, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 wb after release", wb_en, 0);
    check("R10 fault after release", fault, 0);
  endtask

  task automatic t_word_move();
    issue(f_move(3'd2, 3'd5, 1'b1, 1'b1, 1'b0), 16'hA1B2, 16'hC3D4);
    check("R1 idx rd", rd_idx, 2);
    check("R1 idx rs", rs_idx, 5);
    check("R1 no req", mem_req, 0);
    retire();
    check("R1 wb_en", wb_en, 1);
    check("R1 wb_idx", wb_idx, 2);
    check("R11 word ignores byte bits", wb_data, 16'hC3D4);
    @(posedge clk); #1;
    check("R1 single strobe", wb_en, 0);
  endtask

  task automatic t_byte_move();
    logic [15:0] exp [4] = '{16'hA1D4, 16'hA1C3, 16'hD4B2, 16'hC3B2};
    for (int k = 0; k < 4; k++) begin
      issue(f_move(3'd1, 3'd6, k[1], k[0], 1'b1), 16'hA1B2, 16'hC3D4);
      retire();
      check("R2 wb_en", wb_en, 1);
      check("R2 byte placement", wb_data, exp[k]);
    end
  endtask

  task automatic t_imm();
    issue(f_imm(3'd4, 1'b0, 8'h5A), 16'h1234, 16'h0000);
    retire();
    check("R3 wb_idx", wb_idx, 4);
    check("R3 low byte", wb_data, 16'h125A);
    issue(f_imm(3'd4, 1'b1, 8'h5A), 16'h1234, 16'h0000);
    check("R3 no req", mem_req, 0);
    retire();
    check("R3 high byte", wb_data, 16'h5A34);
  endtask

  task automatic t_store_word();
    issue(f_store(3'd0, 3'd1, 1'b0, 1'b0), 16'h0010, 16'hBEEF);
    check("R4 req", mem_req, 1);
    check("R4 we", mem_we, 1);
    check("R4 be", mem_be, 2'b11);
    check("R4 addr", mem_addr, 16'h0010);
    check("R4 wdata", mem_wdata, 16'hBEEF);
    retire();
    check("R4 no wb", wb_en, 0);
  endtask

  task automatic t_store_byte();
    issue(f_store(3'd0, 3'd1, 1'b1, 1'b1), 16'h0021, 16'h7788);
    check("R5 odd be", mem_be, 2'b10);
    check("R5 odd lane data", mem_wdata[15:8], 8'h77);
    retire();
    issue(f_store(3'd0, 3'd1, 1'b0, 1'b1), 16'h0020, 16'h7788);
    check("R5 even be", mem_be, 2'b01);
    check("R5 even lane data", mem_wdata[7:0], 8'h88);
    retire();
    check("R5 no wb", wb_en, 0);
  endtask

  task automatic t_load_word();
    issue(f_load(3'd3, 3'd2, 1'b0, 1'b0), 16'hFFFF, 16'h0010);
    check("R6 req", mem_req, 1);
    check("R6 we", mem_we, 0);
    check("R6 addr", mem_addr, 16'h0010);
    retire();
    check("R6 wb_en", wb_en, 1);
    check("R6 wb_idx", wb_idx, 3);
    check("R6 data", wb_data, 16'hBEEF);
    issue(f_load(3'd3, 3'd2, 1'b0, 1'b0), 16'hFFFF, 16'h0020);
    retire();
    check("R6 data after byte stores", wb_data, 16'h7788);
  endtask

  task automatic t_load_byte();
    issue(f_load(3'd5, 3'd2, 1'b1, 1'b1), 16'h1111, 16'h0021);
    check("R7 be odd", mem_be, 2'b10);
    retire();
    check("R7 odd lane to high byte", wb_data, 16'h7711);
    issue(f_load(3'd5, 3'd2, 1'b0, 1'b1), 16'h1111, 16'h0020);
    retire();
    check("R7 even lane to low byte", wb_data, 16'h1188);
  endtask

  task automatic t_misalign();
    issue(f_store(3'd0, 3'd1, 1'b0, 1'b0), 16'h0013, 16'hDEAD);
    check("R8 store no req", mem_req, 0);
    retire();
    check("R8 store fault", fault, 1);
    check("R8 store no wb", wb_en, 0);
    @(posedge clk); #1;
    check("R8 fault one cycle", fault, 0);
    issue(f_load(3'd6, 3'd2, 1'b0, 1'b0), 16'h0000, 16'h0015);
    check("R8 load no req", mem_req, 0);
    retire();
    check("R8 load fault", fault, 1);
    check("R8 load no wb", wb_en, 0);
    issue(f_load(3'd6, 3'd2, 1'b0, 1'b0), 16'h0000, 16'h0012);
    retire();
    check("R8 memory untouched", wb_data, 16'h0000);
  endtask

  task automatic t_ignored();
    issue(16'h0123, 16'h0010, 16'h0010);
    check("R9 other opcode no req", mem_req, 0);
    retire();
    check("R9 other opcode no wb", wb_en, 0);
    check("R9 other opcode no fault", fault, 0);
    issue(f_load(3'd1, 3'd2, 1'b0, 1'b0) | 16'h0002, 16'h0000, 16'h0010);
    check("R9 reserved bit no req", mem_req, 0);
    retire();
    check("R9 reserved bit no wb", wb_en, 0);
    issue(f_store(3'd0, 3'd1, 1'b0, 1'b0), 16'h0010, 16'h1234);
    valid = 1'b0;
    #0.5;
    check("R9 invalid no req", mem_req, 0);
    retire();
    check("R9 invalid no wb", wb_en, 0);
    issue(f_load(3'd1, 3'd2, 1'b0, 1'b0), 16'h0000, 16'h0010);
    retire();
    check("R9 invalid store left memory", wb_data, 16'hBEEF);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #1;
    t_reset();
    t_word_move();
    t_byte_move();
    t_imm();
    t_store_word();
    t_store_byte();
    t_load_word();
    t_load_byte();
    t_misalign();
    t_ignored();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule